// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a combinational integer ALU assembled from a row of identical one-bit cells. Every cell holds a full adder, an AND gate and an OR gate. A 2-bit operation select picks what each cell drives onto its result bit: the AND output, the OR output, the adder sum, or a "less" input. A shared invert line does two things. It complements operand b in every cell, and it also drives the carry into the lowest cell, so the adder chain computes a + ~b + 1 when subtraction is wanted. Carries ripple from each cell into the next one up.

The top cell also produces two outputs of its own. The first is a signed overflow flag, the XOR of the carry into the top bit and the carry out of it. The second is a sign-of-difference bit, the raw top sum XOR overflow. That bit is routed back to the "less" input of the lowest cell. Every other cell has its "less" input tied low. With this wiring, the signed set-on-less-than result comes out of the same adder chain and needs no separate comparator. A zero flag reports an all-zero result. The control word is `{invert, op[1:0]}`.

Top module: `sliced_alu`

## Requirements
- R1: When ctl = 3'b000, result equals a AND b, bit by bit.
- R2: When ctl = 3'b001, result equals a OR b, bit by bit.
- R3: When ctl = 3'b010, result equals (a + b) modulo 2^W.
- R4: When ctl = 3'b110, result equals (a - b) modulo 2^W.
- R5: When ctl = 3'b111, result is 1 if a < b as two's-complement signed numbers and 0 otherwise, with all upper bits zero. This holds also when a - b overflows.
- R6: zero is 1 exactly when every bit of result is 0.
- R7: For every ctl, overflow is 1 exactly when the signed sum a + b' + ctl[2] overflows, where b' = ~b if ctl[2] = 1 and b' = b if ctl[2] = 0. The sum overflows when a and b' share a sign bit and the sum's sign bit differs from it.
- R8: With ctl[2] = 1, the logic operations see the complemented b: ctl = 3'b100 gives a AND ~b, and ctl = 3'b101 gives a OR ~b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand |
| b | input | W | Second operand |
| ctl | input | 3 | {invert b / carry-in, op[1:0]}; op 0=AND, 1=OR, 2=sum, 3=less |
| result | output | W | Selected result |
| zero | output | 1 | High when result is all zero |
| overflow | output | 1 | Signed overflow of the adder chain |

## Verification
The assertions inside the block compare the rippled cell outputs against word-level arithmetic. They only evaluate when a, b and ctl carry no unknown bits, so they rely on the operands being fully driven whenever a result is read. The bench drives every input to a defined value from time zero and never leaves one floating. Its operands include values at the signed extremes, so that set-on-less-than is checked in the cases where the subtraction overflows.

// File: rtl/sliced_alu.sv
module sliced_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   ctl,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         overflow
);
  logic       inv;
  logic [1:0] op;
  logic       setbit;

  assign inv = ctl[2];
  assign op  = ctl[1:0];

  for (genvar i = 0; i < W; i++) begin : sl
    logic bx, cin, s, co, lt, r;
    if (i == 0) begin : g_lo
      assign cin = inv;
      assign lt  = setbit;
    end else begin : g_hi
      assign cin = sl[i-1].co;
      assign lt  = 1'b0;
    end
    assign bx = b[i] ^ inv;
    assign s  = a[i] ^ bx ^ cin;
    assign co = (a[i] & bx) | (cin & (a[i] ^ bx));
    always_comb begin
      case (op)
        2'd0:    r = a[i] & bx;
        2'd1:    r = a[i] | bx;
        2'd2:    r = s;
        default: r = lt;
      endcase
    end
    assign result[i] = r;
  end

  assign overflow = sl[W-1].cin ^ sl[W-1].co;
  assign setbit   = sl[W-1].s ^ overflow;
  assign zero     = ~|result;

  always_comb begin
    if (!$isunknown({a, b, ctl})) begin
      if (ctl == 3'b010)
        a_r3_add_chain: assert (result == W'(a + b));
      if (ctl == 3'b110)
        a_r4_sub_chain: assert (result == W'(a - b));
      if (ctl == 3'b111)
        a_r5_slt_signed: assert (result == W'($signed(a) < $signed(b)));
      if (ctl[1:0] == 2'b11)
        a_r5_slt_upper_clear: assert (result[W-1:1] == '0);
      if (ctl == 3'b010)
        a_r7_add_overflow: assert (overflow ==
          ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])));
      if (ctl == 3'b110)
        a_r7_sub_overflow: assert (overflow ==
          ((a[W-1] != b[W-1]) && (result[W-1] != a[W-1])));
    end
  end
endmodule

// File: tb/sim_sliced_alu.sv
module sim_sliced_alu;
  localparam int W = 32;
  localparam int N = 13;

  localparam logic [W-1:0] VA [N] = '{
    32'hF0F0F0F0, 32'hF0F0F0F0, 32'h00000005, 32'hFFFFFFFF, 32'h00000005,
    32'h12345678, 32'hFFFFFFFD, 32'h00000002, 32'h80000000, 32'h7FFFFFFF,
    32'hFFFF0000, 32'h00000000, 32'h00000005};
  localparam logic [W-1:0] VB [N] = '{
    32'hFF00FF00, 32'hFF00FF00, 32'h00000007, 32'h00000001, 32'h00000007,
    32'h12345678, 32'h00000002, 32'hFFFFFFFD, 32'h00000001, 32'hFFFFFFFF,
    32'h0F0F0F0F, 32'hFFFF0000, 32'h00000005};
  localparam logic [2:0] VC [N] = '{
    3'b000, 3'b001, 3'b010, 3'b010, 3'b110,
    3'b110, 3'b111, 3'b111, 3'b111, 3'b111,
    3'b100, 3'b101, 3'b111};
  localparam logic [W-1:0] VR [N] = '{
    32'hF000F000, 32'hFFF0FFF0, 32'h0000000C, 32'h00000000, 32'hFFFFFFFE,
    32'h00000000, 32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000,
    32'hF0F00000, 32'h0000FFFF, 32'h00000000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, result;
  logic [2:0] ctl;
  logic zero, overflow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sliced_alu #(.W(W)) u0 (
    .a(a), .b(b), .ctl(ctl),
    .result(result), .zero(zero), .overflow(overflow)
  );

  function automatic logic exp_ovf(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c);
    logic [W-1:0] yy, s;
    yy = c[2] ? ~y : y;
    s  = x + yy + W'(c[2]);
    return (x[W-1] == yy[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c);
    @(posedge clk);
    a = x; b = y; ctl = c;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; ctl = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state result", result, '0);
    check("R6 reset state zero", W'(zero), W'(1));
    check("R7 reset state overflow", W'(overflow), W'(0));

    for (int i = 0; i < N; i++) begin
      apply(VA[i], VB[i], VC[i]);
      check("R1/R2/R3/R4/R5/R8 vector result", result, VR[i]);
      check("R6 vector zero", W'(zero), W'(VR[i] == '0));
      check("R7 vector overflow", W'(overflow), W'(exp_ovf(VA[i], VB[i], VC[i])));
    end

    apply(32'h7FFFFFFF, 32'h00000001, 3'b010);
    check("R3 wrap to negative", result, 32'h80000000);
    check("R7 add positive overflow", W'(overflow), W'(1));
    apply(32'h80000000, 32'h00000001, 3'b110);
    check("R4 wrap to positive", result, 32'h7FFFFFFF);
    check("R7 sub negative overflow", W'(overflow), W'(1));
    apply(32'h80000000, 32'h80000000, 3'b010);
    check("R6 add carries out to zero", W'(zero), W'(1));
    check("R7 add two negatives overflow", W'(overflow), W'(1));
    apply(32'h00000001, 32'h00000000, 3'b000);
    check("R6 nonzero inputs give zero AND", W'(zero), W'(1));
    apply(32'h80000000, 32'h7FFFFFFF, 3'b111);
    check("R5 most negative below most positive", result, 32'h00000001);
    apply(32'h00000000, 32'h00000001, 3'b111);
    check("R5 zero below one", result, 32'h00000001);
    check("R6 slt true not zero", W'(zero), W'(0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule